// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block is a small synchronous supervisor that runs from a slow timebase clock. It keeps a processor in reset while a digitized low-supply flag is active. Once the flag clears, it holds reset for a fixed stretch. It then watches a strobe line that software must toggle. If the strobe holds one level for longer than the selected timeout, the block raises a fault output and issues a reset pulse of the same stretch width. It keeps issuing such pulses for as long as the strobe stays idle.

After every reset the long timeout applies. The short timeout, which is chosen by `short_sel_i`, takes effect only after the first strobe transition seen outside reset. A separate flag marks the strobe as undriven, and while it is set the watchdog is disabled.

The three asynchronous inputs pass through a two-flop synchronizer. The strobe edge is found by comparing each synchronized sample with the previous one.

The control is a three-state machine:
- `WDS_LOWLINE`: reset is held while low-line is active.
- `WDS_STRETCH`: reset is held while a hold counter runs.
- `WDS_RUN`: reset is released and the watchdog counts.

Its transitions are:
- any state to `WDS_LOWLINE` on low-line;
- `WDS_LOWLINE` to `WDS_STRETCH` when low-line clears;
- `WDS_STRETCH` to `WDS_RUN` when the hold count completes;
- `WDS_RUN` to `WDS_STRETCH` on a watchdog expiry.

The asynchronous power-on reset enters `WDS_STRETCH` with the hold count at zero.

Top module: `wd_supervisor`

## Requirements
- R1: While `low_line_i` is 1, `reset_n_o` is 0. It falls on the third rising clock edge after `low_line_i` rises.
- R2: `reset_n_o` returns to 1 exactly HOLD_TICKS edges after the stretch starts. After a low-line release the stretch starts on the third edge, so the release takes HOLD_TICKS+3 edges. After the power-on reset is released the stretch starts at once, so the release takes HOLD_TICKS edges.
- R3: Every rising or falling transition of `strobe_i` restarts the watchdog count. Toggling at intervals shorter than the timeout keeps `reset_n_o` at 1 indefinitely.
- R4: When the strobe stays idle, a reset pulse of exactly HOLD_TICKS edges is issued each time the timeout elapses. The pulses repeat with LONG_TICKS edges of release between them.
- R5: The long timeout (LONG_TICKS) applies after every reset, whatever `short_sel_i` is. The short timeout (SHORT_TICKS) applies only when `short_sel_i`=1 and a strobe transition has occurred since reset ended. Measured from a strobe transition, the short timeout is reached after SHORT_TICKS+3 edges.
- R6: Strobe transitions that occur while reset is asserted are ignored. They neither clear the fault output nor change the reset width.
- R7: `wd_fault_n_o` falls to 0 on the edge at which a timeout asserts reset. It returns to 1 on the third edge after a strobe transition made while reset is inactive.
- R8: While low-line is active, `wd_fault_n_o` is forced to 1.
- R9: While `strobe_float_i` is 1, no timeout occurs and `wd_fault_n_o` keeps its value. Counting restarts from zero once the flag clears, so the timeout is reached TIMEOUT+2 edges after the flag is cleared.
- R10: `reset_o` is always the inverse of `reset_n_o`.
- R11: During the asynchronous power-on reset, `reset_n_o`=0, `reset_o`=1 and `wd_fault_n_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| low_line_i | input | 1 | Low-supply flag, 1 = supply too low |
| strobe_i | input | 1 | Watchdog strobe toggled by software |
| strobe_float_i | input | 1 | 1 = strobe undriven, watchdog disabled |
| short_sel_i | input | 1 | 1 = short timeout once armed, 0 = always long |
| reset_n_o | output | 1 | Reset, active low |
| reset_o | output | 1 | Reset, active high |
| wd_fault_n_o | output | 1 | Watchdog fault latch, 0 = timeout occurred |

## Verification
Each asynchronous input reaches the state machine on the third clock edge after it changes: two synchronizer stages plus the edge or state register. Low-line therefore asserts reset after 3 edges and releases it after HOLD_TICKS+3 edges. A strobe-timed expiry lands after TIMEOUT+3 edges, and an expiry timed from the reset release lands after exactly TIMEOUT edges. The bench drives every input on a falling edge and counts falling edges until the output changes, so each count equals the number of rising edges elapsed. It compares that count exactly against these formulas and does not accept a window.

// File: rtl/wds_pkg.sv
package wds_pkg;
    typedef enum logic [1:0] {
        WDS_LOWLINE = 2'd0,
        WDS_STRETCH = 2'd1,
        WDS_RUN     = 2'd2
    } wds_state_e;
endpackage

// File: rtl/wds_sync.sv
module wds_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/wds_wdog.sv
module wds_wdog #(
    parameter int LONG_TICKS  = 4096,
    parameter int SHORT_TICKS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic edge_i,
    input  logic float_i,
    input  logic short_sel_i,
    output logic expire_o
);
    localparam int CW = $clog2(LONG_TICKS + 1);
    localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);
    localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);

    logic [CW-1:0] cnt_q;
    logic          long_q;
    logic [CW-1:0] last;

    assign last     = (long_q || !short_sel_i) ? LONG_LAST : SHORT_LAST;
    assign expire_o = run_i && !float_i && !edge_i && (cnt_q == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            long_q <= 1'b1;
        end else begin
            if (!run_i || float_i || edge_i || expire_o) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (!run_i) begin
                long_q <= 1'b1;
            end else if (edge_i) begin
                long_q <= 1'b0;
            end
        end
    end

    // R5
    grace_after_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> long_q);
    // R3
    strobe_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_i |=> (cnt_q == '0));
    // R9
    float_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        float_i |=> (cnt_q == '0));
    // R4
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LONG_LAST);
endmodule

// File: rtl/wds_fsm.sv
module wds_fsm
    import wds_pkg::*;
#(
    parameter int HOLD_TICKS = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_i,
    input  logic edge_i,
    input  logic expire_i,
    output logic run_o,
    output logic fault_n_o
);
    localparam int HW = $clog2(HOLD_TICKS + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_TICKS - 1);

    wds_state_e    state_q, state_d;
    logic [HW-1:0] hold_q, hold_d;
    logic          fault_n_q;

    always_comb begin
        state_d = state_q;
        hold_d  = hold_q;
        unique case (state_q)
            WDS_LOWLINE: begin
                if (!low_i) begin
                    state_d = WDS_STRETCH;
                    hold_d  = '0;
                end
            end
            WDS_STRETCH: begin
                if (low_i) begin
                    state_d = WDS_LOWLINE;
                end else if (hold_q == HOLD_LAST) begin
                    state_d = WDS_RUN;
                end else begin
                    hold_d = hold_q + 1'b1;
                end
            end
            WDS_RUN: begin
                if (low_i) begin
                    state_d = WDS_LOWLINE;
                end else if (expire_i) begin
                    state_d = WDS_STRETCH;
                    hold_d  = '0;
                end
            end
            default: state_d = WDS_LOWLINE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WDS_STRETCH;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            hold_q  <= hold_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_n_q <= 1'b1;
        end else if (low_i) begin
            fault_n_q <= 1'b1;
        end else if (state_q == WDS_RUN && expire_i) begin
            fault_n_q <= 1'b0;
        end else if (state_q == WDS_RUN && edge_i) begin
            fault_n_q <= 1'b1;
        end
    end

    assign run_o     = (state_q == WDS_RUN);
    assign fault_n_o = fault_n_q;

    // R1
    lowline_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_i |=> !run_o);
    // R2
    stretch_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_o) |-> ($past(hold_q) == HOLD_LAST));
    // R6
    ignore_in_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && edge_i && !low_i) |=> $stable(fault_n_o));
    // R7
    fault_on_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_o && expire_i && !low_i) |=> (!fault_n_o && !run_o));
    // R8
    lowline_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_i |=> fault_n_o);
endmodule

// File: rtl/wd_supervisor.sv
module wd_supervisor #(
    parameter int HOLD_TICKS  = 512,
    parameter int LONG_TICKS  = 4096,
    parameter int SHORT_TICKS = 1024
) (
    input  logic clk,
    input  logic rst_n,
    input  logic low_line_i,
    input  logic strobe_i,
    input  logic strobe_float_i,
    input  logic short_sel_i,
    output logic reset_n_o,
    output logic reset_o,
    output logic wd_fault_n_o
);
    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] raw_in, syn_out;
    logic low_s, strobe_s, float_s, strobe_prev_q, strobe_edge;
    logic run, expire;

    assign raw_in = {strobe_float_i, strobe_i, low_line_i};

    wds_sync #(.WIDTH(SYNC_W), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (syn_out)
    );

    assign low_s    = syn_out[0];
    assign strobe_s = syn_out[1];
    assign float_s  = syn_out[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_prev_q <= 1'b0;
        end else begin
            strobe_prev_q <= strobe_s;
        end
    end

    assign strobe_edge = strobe_s ^ strobe_prev_q;

    wds_wdog #(.LONG_TICKS(LONG_TICKS), .SHORT_TICKS(SHORT_TICKS)) u_wdog (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .edge_i      (strobe_edge),
        .float_i     (float_s),
        .short_sel_i (short_sel_i),
        .expire_o    (expire)
    );

    wds_fsm #(.HOLD_TICKS(HOLD_TICKS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .low_i     (low_s),
        .edge_i    (strobe_edge),
        .expire_i  (expire),
        .run_o     (run),
        .fault_n_o (wd_fault_n_o)
    );

    assign reset_n_o = run;
    assign reset_o   = !run;
endmodule

// File: tb/tb_wd_supervisor.sv
module tb_wd_supervisor;
    localparam int HOLD  = 8;
    localparam int LONG  = 64;
    localparam int SHORT = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic low_line = 1'b0, strobe = 1'b0, flt = 1'b0, short_sel = 1'b1;
    logic reset_n_o, reset_o, wd_fault_n_o;

    int checks = 0;
    int errors = 0;
    int inv_err = 0;

    always #4 clk = ~clk;

    wd_supervisor #(.HOLD_TICKS(HOLD), .LONG_TICKS(LONG), .SHORT_TICKS(SHORT)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .low_line_i     (low_line),
        .strobe_i       (strobe),
        .strobe_float_i (flt),
        .short_sel_i    (short_sel),
        .reset_n_o      (reset_n_o),
        .reset_o        (reset_o),
        .wd_fault_n_o   (wd_fault_n_o)
    );

    // R10 monitor
    always @(negedge clk) if (reset_o !== !reset_n_o) inv_err++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rst(input logic lvl, input int maxc, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (reset_n_o !== lvl && n < maxc);
    endtask

    task automatic t_power_on();
        int n;
        repeat (3) @(negedge clk);
        chk(reset_n_o === 1'b0 && reset_o === 1'b1, "R11 reset_n", int'(reset_n_o), 0);
        chk(wd_fault_n_o === 1'b1, "R11 fault_n", int'(wd_fault_n_o), 1);
        rst_n = 1'b1;
        wait_rst(1'b1, 1000, n);
        chk(n == HOLD, "R2 power-on stretch", n, HOLD);
    endtask

    task automatic t_grace_repeat();
        int n;
        wait_rst(1'b0, 1000, n);
        chk(n == LONG, "R5 grace is long", n, LONG);
        chk(wd_fault_n_o === 1'b0, "R7 fault on timeout", int'(wd_fault_n_o), 0);
        wait_rst(1'b1, 1000, n);
        chk(n == HOLD, "R4 pulse width", n, HOLD);
        wait_rst(1'b0, 1000, n);
        chk(n == LONG, "R4 repeat period", n, LONG);
    endtask

    task automatic t_ignore_in_reset();
        int n;
        strobe = ~strobe;
        wait_rst(1'b1, 1000, n);
        chk(n == HOLD, "R6 width unchanged", n, HOLD);
        chk(wd_fault_n_o === 1'b0, "R6 fault kept", int'(wd_fault_n_o), 0);
    endtask

    task automatic t_short_after_edge();
        int n;
        strobe = ~strobe;
        repeat (3) @(negedge clk);
        chk(wd_fault_n_o === 1'b1, "R7 fault cleared", int'(wd_fault_n_o), 1);
        wait_rst(1'b0, 1000, n);
        chk(n + 3 == SHORT + 3, "R5 short timeout", n + 3, SHORT + 3);
        wait_rst(1'b1, 1000, n);
        chk(n == HOLD, "R4 pulse width short", n, HOLD);
        wait_rst(1'b0, 1000, n);
        chk(n == LONG, "R5 long again after reset", n, LONG);
        wait_rst(1'b1, 1000, n);
    endtask

    task automatic t_keepalive();
        int n;
        int bad = 0;
        short_sel = 1'b0;
        for (int k = 0; k < 6; k++) begin
            repeat (LONG / 2) begin
                @(negedge clk);
                if (reset_n_o !== 1'b1) bad++;
            end
            strobe = ~strobe;
        end
        chk(bad == 0, "R3 keepalive no reset", bad, 0);
        wait_rst(1'b0, 1000, n);
        chk(n == LONG + 3, "R3 restart on edge, long sel", n, LONG + 3);
        chk(wd_fault_n_o === 1'b0, "R7 fault after keepalive stop", int'(wd_fault_n_o), 0);
        wait_rst(1'b1, 1000, n);
        short_sel = 1'b1;
    endtask

    task automatic t_float();
        int n;
        int bad = 0;
        strobe = ~strobe;
        repeat (4) @(negedge clk);
        flt = 1'b1;
        repeat (3 * LONG) begin
            @(negedge clk);
            if (reset_n_o !== 1'b1 || wd_fault_n_o !== 1'b1) bad++;
        end
        chk(bad == 0, "R9 float disables", bad, 0);
        flt = 1'b0;
        wait_rst(1'b0, 1000, n);
        chk(n == SHORT + 2, "R9 restart after float", n, SHORT + 2);
    endtask

    task automatic t_lowline();
        int n;
        int bad = 0;
        wait_rst(1'b1, 1000, n);
        chk(wd_fault_n_o === 1'b0, "R7 fault still low", int'(wd_fault_n_o), 0);
        low_line = 1'b1;
        wait_rst(1'b0, 1000, n);
        chk(n == 3, "R1 low-line latency", n, 3);
        chk(wd_fault_n_o === 1'b1, "R8 fault forced high", int'(wd_fault_n_o), 1);
        repeat (20) begin
            @(negedge clk);
            if (reset_n_o !== 1'b0) bad++;
        end
        chk(bad == 0, "R1 held during low-line", bad, 0);
        low_line = 1'b0;
        wait_rst(1'b1, 1000, n);
        chk(n == HOLD + 3, "R2 release stretch", n, HOLD + 3);
        wait_rst(1'b0, 1000, n);
        chk(n == LONG, "R5 long after low-line reset", n, LONG);
    endtask

    initial begin
        t_power_on();
        t_grace_repeat();
        t_ignore_in_reset();
        t_short_after_edge();
        t_keepalive();
        t_float();
        t_lowline();
        chk(inv_err == 0, "R10 inverse outputs", inv_err, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule